// File: doc/BRIEF.md
# ECC Diagnostic Error Logger

This block sits beside an ECC decoder and records what the decoder reports. It runs on its own diagnostic clock. On every rising edge it samples the check bits, the syndrome, two error flags (single-bit and multi-bit) and the data word the decoder is presenting. From these samples it keeps three kinds of record. The first is a saturating count of the cycles in which an error was flagged. The second is a frozen snapshot of the first error seen since the last diagnostic reset. The third is a syndrome register that follows the decoder on every edge.

All records are visible on output ports, so diagnostic software or a debug path can read them at any time. A synchronous, active-high diagnostic reset clears the counter, the snapshot and the captured flag. Clearing them re-arms the logger, so the next error is captured again.

Top module: `ecc_diag_logger`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `err_count`, `cap_valid`, `cap_chk`, `cap_syn`, `cap_kind`, `cap_data` and `live_syn` are all zero.
- R2: An edge is an error edge when `err_single` or `err_multi` is high. Each error edge raises `err_count` by exactly one while it is below its maximum.
- R3: `err_count` saturates at 15 (all ones for the 4-bit default). Further error edges leave it at 15.
- R4: An edge with neither error flag high leaves `err_count` unchanged.
- R5: On the first error edge after reset, `cap_chk`, `cap_syn`, `cap_data` and `cap_kind` are loaded together from that edge's inputs, and `cap_valid` goes to 1.
- R6: While `cap_valid` is 1, later error edges change none of `cap_chk`, `cap_syn`, `cap_kind`, `cap_data` or `cap_valid`.
- R7: `cap_kind` is encoded as 2'b00 for none, 2'b01 for single and 2'b10 for multiple. When both flags are high, multiple wins. The value 2'b11 never appears.
- R8: `live_syn` takes the value of `syn_in` on every edge outside reset, whether or not an error is flagged.
- R9: A reset after a capture re-arms the logger, so the next error edge is captured with its own values.
- R10: Edges without an error before the first capture leave `cap_valid` at 0 and the snapshot fields at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Diagnostic clock |
| rst | input | 1 | Synchronous active-high diagnostic reset |
| chk_in | input | CHK_W | Check bits of the current word |
| syn_in | input | CHK_W | Syndrome of the current word |
| err_single | input | 1 | Decoder flags a correctable single-bit error |
| err_multi | input | 1 | Decoder flags an uncorrectable multi-bit error |
| data_in | input | DATA_W | Data word as read |
| err_count | output | CNT_W | Saturating error count |
| cap_valid | output | 1 | Snapshot holds a captured error |
| cap_chk | output | CHK_W | Captured check bits |
| cap_syn | output | CHK_W | Captured syndrome |
| cap_kind | output | 2 | Captured error type |
| cap_data | output | DATA_W | Captured data word |
| live_syn | output | CHK_W | Syndrome from the latest edge |

## Verification
A counter that skips, wraps or fails to hold shows up as a wrong `err_count` one cycle after the offending edge. The 20-error burst shows a wrap past 15 directly. A snapshot that is not frozen shows up as a change in `cap_data` or `cap_syn` one cycle after the second error. Different data is driven on every error so that such a change cannot be hidden. A wrong re-arm or a wrong type encoding appears in the snapshot on the cycle right after the relevant reset or error edge.

// File: rtl/ecc_diag_pkg.sv
package ecc_diag_pkg;

    localparam int DEF_DATA_W = 64;
    localparam int DEF_CHK_W  = 8;
    localparam int DEF_CNT_W  = 4;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'b00,
        KIND_SINGLE = 2'b01,
        KIND_MULTI  = 2'b10
    } err_kind_e;

    typedef struct packed {
        logic multi;
        logic single;
    } err_flags_t;

    function automatic err_kind_e classify(input err_flags_t f);
        if (f.multi)
            return KIND_MULTI;
        else if (f.single)
            return KIND_SINGLE;
        else
            return KIND_NONE;
    endfunction

    function automatic logic any_error(input err_flags_t f);
        return f.multi | f.single;
    endfunction

endpackage

// File: rtl/diag_sat_counter.sv
module diag_sat_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;
    logic             at_max;

    assign at_max = (count_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (inc && !at_max)
            count_q <= count_q + 1'b1;
    end

    assign count = count_q;
endmodule

// File: rtl/diag_syn_track.sv
module diag_syn_track #(
    parameter int CHK_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CHK_W-1:0] syn_in,
    output logic [CHK_W-1:0] syn_q
);
    always_ff @(posedge clk) begin
        if (rst)
            syn_q <= '0;
        else
            syn_q <= syn_in;
    end
endmodule

// File: rtl/diag_snapshot.sv
module diag_snapshot
    import ecc_diag_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  err_flags_t        flags,
    input  logic [CHK_W-1:0]  chk_in,
    input  logic [CHK_W-1:0]  syn_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              valid,
    output logic [CHK_W-1:0]  chk_q,
    output logic [CHK_W-1:0]  syn_q,
    output err_kind_e         kind_q,
    output logic [DATA_W-1:0] data_q
);
    localparam int BYTES = (DATA_W + 7) / 8;

    logic take;

    assign take = any_error(flags) && !valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            chk_q  <= '0;
            syn_q  <= '0;
            kind_q <= KIND_NONE;
        end else if (take) begin
            valid  <= 1'b1;
            chk_q  <= chk_in;
            syn_q  <= syn_in;
            kind_q <= classify(flags);
        end
    end

    // The data word is held in byte lanes that all share one load strobe.
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        localparam int LO = b * 8;
        localparam int HI = ((b * 8 + 7) < DATA_W) ? (b * 8 + 7) : (DATA_W - 1);
        always_ff @(posedge clk) begin
            if (rst)
                data_q[HI:LO] <= '0;
            else if (take)
                data_q[HI:LO] <= data_in[HI:LO];
        end
    end
endmodule

// File: rtl/ecc_diag_logger.sv
module ecc_diag_logger
    import ecc_diag_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int CHK_W  = DEF_CHK_W,
    parameter int CNT_W  = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CHK_W-1:0]  chk_in,
    input  logic [CHK_W-1:0]  syn_in,
    input  logic              err_single,
    input  logic              err_multi,
    input  logic [DATA_W-1:0] data_in,
    output logic [CNT_W-1:0]  err_count,
    output logic              cap_valid,
    output logic [CHK_W-1:0]  cap_chk,
    output logic [CHK_W-1:0]  cap_syn,
    output logic [1:0]        cap_kind,
    output logic [DATA_W-1:0] cap_data,
    output logic [CHK_W-1:0]  live_syn
);
    err_flags_t flags;
    err_kind_e  kind_w;

    assign flags.single = err_single;
    assign flags.multi  = err_multi;

    diag_sat_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .inc   (any_error(flags)),
        .count (err_count)
    );

    diag_snapshot #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_snap (
        .clk     (clk),
        .rst     (rst),
        .flags   (flags),
        .chk_in  (chk_in),
        .syn_in  (syn_in),
        .data_in (data_in),
        .valid   (cap_valid),
        .chk_q   (cap_chk),
        .syn_q   (cap_syn),
        .kind_q  (kind_w),
        .data_q  (cap_data)
    );

    assign cap_kind = kind_w;

    diag_syn_track #(.CHK_W(CHK_W)) u_syn (
        .clk    (clk),
        .rst    (rst),
        .syn_in (syn_in),
        .syn_q  (live_syn)
    );
endmodule

// File: rtl/ecc_diag_logger_chk.sv
module ecc_diag_logger_chk #(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [CHK_W-1:0]  syn_in,
    input logic [CHK_W-1:0]  chk_in,
    input logic              err_single,
    input logic              err_multi,
    input logic [DATA_W-1:0] data_in,
    input logic [CNT_W-1:0]  err_count,
    input logic              cap_valid,
    input logic [CHK_W-1:0]  cap_chk,
    input logic [CHK_W-1:0]  cap_syn,
    input logic [1:0]        cap_kind,
    input logic [DATA_W-1:0] cap_data,
    input logic [CHK_W-1:0]  live_syn
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic err;
    assign err = err_single | err_multi;

    // R2
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (err && err_count != TOP) |=> err_count == $past(err_count) + 1'b1);

    // R3
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (err_count == TOP) |=> err_count == TOP);

    // R4
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !err |=> $stable(err_count));

    // R5
    a_r5_first_take: assert property (@(posedge clk) disable iff (rst)
        (err && !cap_valid) |=> cap_valid && cap_data == $past(data_in)
            && cap_chk == $past(chk_in) && cap_syn == $past(syn_in));

    // R6
    a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
        cap_valid |=> cap_valid && $stable(cap_data) && $stable(cap_chk)
            && $stable(cap_syn) && $stable(cap_kind));

    // R7
    a_r7_kind_legal: assert property (@(posedge clk) disable iff (rst)
        cap_kind != 2'b11);

    // R8
    a_r8_live_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> rst || live_syn == $past(syn_in));

    // R10
    a_r10_idle_no_take: assert property (@(posedge clk) disable iff (rst)
        (!err && !cap_valid) |=> !cap_valid);
endmodule

bind ecc_diag_logger ecc_diag_logger_chk #(
    .DATA_W(DATA_W), .CHK_W(CHK_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .syn_in(syn_in), .chk_in(chk_in),
    .err_single(err_single), .err_multi(err_multi), .data_in(data_in),
    .err_count(err_count), .cap_valid(cap_valid), .cap_chk(cap_chk),
    .cap_syn(cap_syn), .cap_kind(cap_kind), .cap_data(cap_data),
    .live_syn(live_syn)
);

// File: tb/test_ecc_diag_logger.sv
module test_ecc_diag_logger;
    localparam int DW = 64;
    localparam int CW = 8;
    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] chk_in = '0;
    logic [CW-1:0] syn_in = '0;
    logic          err_single = 1'b0;
    logic          err_multi = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic [NW-1:0] err_count;
    logic          cap_valid;
    logic [CW-1:0] cap_chk;
    logic [CW-1:0] cap_syn;
    logic [1:0]    cap_kind;
    logic [DW-1:0] cap_data;
    logic [CW-1:0] live_syn;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    ecc_diag_logger i_ecc_diag_logger (
        .clk(clk), .rst(rst), .chk_in(chk_in), .syn_in(syn_in),
        .err_single(err_single), .err_multi(err_multi), .data_in(data_in),
        .err_count(err_count), .cap_valid(cap_valid), .cap_chk(cap_chk),
        .cap_syn(cap_syn), .cap_kind(cap_kind), .cap_data(cap_data),
        .live_syn(live_syn)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive on the falling edge, let one rising edge pass, settle before sampling.
    task automatic step(input logic r, input logic s, input logic m,
                        input logic [CW-1:0] c, input logic [CW-1:0] y,
                        input logic [DW-1:0] d);
        @(negedge clk);
        rst = r; err_single = s; err_multi = m; chk_in = c; syn_in = y; data_in = d;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        step(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, '0);
    endtask

    task automatic t_reset_state();
        step(1'b1, 1'b1, 1'b1, 8'hFF, 8'hEE, {DW{1'b1}});
        check("R1 count", err_count, 0);
        check("R1 valid", cap_valid, 0);
        check("R1 chk", cap_chk, 0);
        check("R1 syn", cap_syn, 0);
        check("R1 kind", cap_kind, 0);
        check("R1 data", cap_data, 0);
        check("R1 live", live_syn, 0);
    endtask

    task automatic t_idle_cycles();
        do_reset();
        for (int i = 1; i <= 5; i++) begin
            step(1'b0, 1'b0, 1'b0, 8'(i * 3), 8'(8'h10 + i), 64'hDEAD_0000_0000_0000 + 64'(i));
            check("R4 idle count", err_count, 0);
            check("R10 idle valid", cap_valid, 0);
            check("R10 idle data", cap_data, 0);
            check("R8 live idle", live_syn, 8'(8'h10 + i));
        end
    endtask

    task automatic t_first_and_later();
        do_reset();
        step(1'b0, 1'b1, 1'b0, 8'h5A, 8'h23, 64'h0123_4567_89AB_CDEF);
        check("R2 first count", err_count, 1);
        check("R5 valid", cap_valid, 1);
        check("R5 chk", cap_chk, 8'h5A);
        check("R5 syn", cap_syn, 8'h23);
        check("R7 single kind", cap_kind, 2'b01);
        check("R5 data", cap_data, 64'h0123_4567_89AB_CDEF);
        step(1'b0, 1'b0, 1'b1, 8'hA5, 8'h99, 64'hFEDC_BA98_7654_3210);
        check("R2 second count", err_count, 2);
        check("R6 data held", cap_data, 64'h0123_4567_89AB_CDEF);
        check("R6 syn held", cap_syn, 8'h23);
        check("R6 chk held", cap_chk, 8'h5A);
        check("R6 kind held", cap_kind, 2'b01);
        check("R8 live err", live_syn, 8'h99);
        step(1'b0, 1'b0, 1'b0, 8'h00, 8'h42, 64'h0);
        check("R4 hold after err", err_count, 2);
        check("R8 live no err", live_syn, 8'h42);
    endtask

    task automatic t_saturation();
        do_reset();
        for (int i = 1; i <= 20; i++) begin
            step(1'b0, 1'b1, 1'b0, 8'(i), 8'(i + 100), 64'hA000_0000_0000_0000 | 64'(i));
            check("R3 R2 count", err_count, (i < 15) ? i : 15);
            check("R6 burst data", cap_data, 64'hA000_0000_0000_0001);
            check("R6 burst syn", cap_syn, 8'd101);
        end
        step(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 64'h0);
        check("R3 stays at max", err_count, 15);
    endtask

    task automatic t_kind_multi();
        do_reset();
        step(1'b0, 1'b1, 1'b1, 8'h11, 8'h77, 64'h5555_AAAA_5555_AAAA);
        check("R7 both flags multi", cap_kind, 2'b10);
        do_reset();
        step(1'b0, 1'b0, 1'b1, 8'h12, 8'h78, 64'h1);
        check("R7 multi only", cap_kind, 2'b10);
        check("R2 multi counts", err_count, 1);
    endtask

    task automatic t_rearm();
        do_reset();
        step(1'b0, 1'b1, 1'b0, 8'h01, 8'h02, 64'h1111);
        do_reset();
        check("R1 after capture valid", cap_valid, 0);
        check("R1 after capture data", cap_data, 0);
        step(1'b0, 1'b0, 1'b1, 8'hC3, 8'h3C, 64'h2222_3333);
        check("R9 rearm data", cap_data, 64'h2222_3333);
        check("R9 rearm syn", cap_syn, 8'h3C);
        check("R9 rearm chk", cap_chk, 8'hC3);
        check("R9 rearm kind", cap_kind, 2'b10);
    endtask

    initial begin
        #800000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_idle_cycles();
        t_first_and_later();
        t_saturation();
        t_kind_multi();
        t_rearm();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule